// File: doc/BRIEF.md
# Two-Wire Register Slave with Dedicated Acknowledge Output

This block is a serial control slave that fronts a bank of byte-wide configuration registers. The host drives a bus clock line and a data line. The slave never drives the data line. Everything it returns, both acknowledge bits and read data, comes out on a separate single-bit output. Both bus inputs are resynchronised into the system clock, and the protocol logic works from edges it detects there.

A write transfer starts with a start condition and the write address byte. The next byte loads the register pointer. Every byte after that is stored at the pointer, and the pointer then advances, wrapping from the last register back to the first. A read transfer uses the read address byte and presents the bits of the pointed register, inverted, on the acknowledge output. The host acknowledges each byte on the data line. A not-acknowledge ends the output. The whole register bank is visible at all times as one flat parallel bus.

Top module: `sreg_slave_top`

## Requirements
- R1: A falling edge on the data line while the bus clock is high is a start condition. From any state, it begins a new address byte and drives the acknowledge output low.
- R2: A rising edge on the data line while the bus clock is high is a stop condition. It drives the acknowledge output low, and later bus clock pulses have no effect until the next start.
- R3: Each byte takes nine bus clock pulses: eight bits sampled on rising edges, most significant bit first, then one acknowledge slot.
- R4: When the address byte equals 24h, the acknowledge output is high from the falling edge after the eighth bit until the falling edge that ends the ninth pulse.
- R5: The first byte after the write address loads the register pointer from its low seven bits, and it is acknowledged.
- R6: Each later byte in a write transfer is stored at the pointer, then the pointer increments. The byte is acknowledged, and the number of bytes is not limited. Register n appears on regs_o bits [8n+7:8n].
- R7: The pointer wraps from 7Fh to 00h.
- R8: When the address byte equals 25h, it is acknowledged. The output then carries the inverted bits of the register at the pointer, most significant first, each bit set up on the falling edge before its clock pulse. The pointer advances after each byte, and the output is low during the host's acknowledge slot.
- R9: In a read, the host acknowledges with the data line low in the ninth pulse, and the next byte follows. A high data line ends the read, and the output stays low until the next start.
- R10: Any other address byte is not acknowledged. The slave ignores the bus until the next start, and no register changes.
- R11: The pointer keeps its value across stop and start, so a write that only sets the pointer selects where a following read begins.
- R12: After reset, the acknowledge output is low, every register is zero and the pointer is zero.
- R13: The acknowledge output takes a new value on the third system clock edge after the bus clock pin falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Serial bus clock from the host |
| bus_data_i | input | 1 | Serial bus data from the host |
| ack_o | output | 1 | Acknowledge bits and inverted read data |
| regs_o | output | NUM_REGS*DATA_W | All registers, register n in byte lane n |

## Verification
A wrong bit count or a wrong controller state shows up on ack_o within the same byte. The acknowledge either goes missing or lands one bus clock early or late, and the bench samples it in every acknowledge slot. A wrong pointer stays hidden until the next stored byte or the next read. The bench therefore follows each write burst that crosses the wrap point with a read that must return the expected sequence. A model copy of the register bank is compared against regs_o on every system clock between transfers, so a stray write is seen as soon as the transfer that caused it ends.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_RDATA,
        ST_IGNORE
    } slv_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic is_active(input slv_state_e s);
        return (s != ST_IDLE) && (s != ST_IGNORE);
    endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync
    import sreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_pin,
    input  logic    sda_pin,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_pin;
                    sda_ff <= sda_pin;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_pin};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_pin};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
        ev.sda   = sda_s;
    end

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank #(
    parameter int NUM_REGS = 128,
    parameter int DATA_W   = 8,
    localparam int PTR_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [PTR_W-1:0]           waddr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [PTR_W-1:0]           raddr,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_REGS*DATA_W-1:0] flat
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[i] <= '0;
                end else if (we && (waddr == PTR_W'(i))) begin
                    mem[i] <= wdata;
                end
            end
            assign flat[i*DATA_W +: DATA_W] = mem[i];
        end
    endgenerate

    assign rdata = mem[raddr];

endmodule

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
    import sreg_pkg::*;
#(
    parameter int          NUM_REGS = 128,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  WR_ADDR  = 8'h24,
    parameter logic [7:0]  RD_ADDR  = 8'h25,
    localparam int         PTR_W    = $clog2(NUM_REGS),
    localparam int         CNT_W    = $clog2(DATA_W + 1),
    localparam int         IDX_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              we,
    output logic [PTR_W-1:0]  waddr,
    output logic [DATA_W-1:0] wdata,
    output logic [PTR_W-1:0]  ptr,
    output logic              ack_o,
    output slv_state_e        state
);
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              in_ack;
    logic              rd_go;
    logic              mack_due;
    logic              byte_done;
    logic [IDX_W-1:0]  bit_idx;

    assign byte_done = (cnt == CNT_W'(DATA_W));
    assign bit_idx   = IDX_W'(DATA_W - 1) - cnt[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            in_ack   <= 1'b0;
            rd_go    <= 1'b0;
            mack_due <= 1'b0;
            ack_o    <= 1'b0;
            ptr      <= '0;
            we       <= 1'b0;
            waddr    <= '0;
            wdata    <= '0;
        end else begin
            we <= 1'b0;
            if (ev.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                in_ack <= 1'b0;
                ack_o  <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                in_ack <= 1'b0;
                ack_o  <= 1'b0;
            end else if (is_active(state)) begin
                if (ev.rise) begin
                    if (in_ack) begin
                        if (mack_due) rd_go <= ~ev.sda;
                    end else begin
                        shreg <= {shreg[DATA_W-2:0], ev.sda};
                        cnt   <= cnt + 1'b1;
                    end
                end else if (ev.fall) begin
                    if (in_ack) begin
                        in_ack   <= 1'b0;
                        cnt      <= '0;
                        mack_due <= 1'b0;
                        if (state == ST_RDATA) begin
                            if (rd_go) begin
                                ack_o <= ~rd_byte[DATA_W-1];
                            end else begin
                                ack_o <= 1'b0;
                                state <= ST_IGNORE;
                            end
                        end else begin
                            ack_o <= 1'b0;
                        end
                    end else if (byte_done) begin
                        in_ack <= 1'b1;
                        unique case (state)
                            ST_ADDR: begin
                                if (shreg == DATA_W'(WR_ADDR)) begin
                                    state <= ST_PTR;
                                    ack_o <= 1'b1;
                                end else if (shreg == DATA_W'(RD_ADDR)) begin
                                    state    <= ST_RDATA;
                                    ack_o    <= 1'b1;
                                    rd_go    <= 1'b1;
                                    mack_due <= 1'b0;
                                end else begin
                                    state <= ST_IGNORE;
                                    ack_o <= 1'b0;
                                end
                            end
                            ST_PTR: begin
                                ptr   <= shreg[PTR_W-1:0];
                                state <= ST_WDATA;
                                ack_o <= 1'b1;
                            end
                            ST_WDATA: begin
                                we    <= 1'b1;
                                waddr <= ptr;
                                wdata <= shreg;
                                ptr   <= ptr + 1'b1;
                                ack_o <= 1'b1;
                            end
                            ST_RDATA: begin
                                ptr      <= ptr + 1'b1;
                                ack_o    <= 1'b0;
                                mack_due <= 1'b1;
                            end
                            default: ack_o <= 1'b0;
                        endcase
                    end else if ((state == ST_RDATA) && (cnt != '0)) begin
                        ack_o <= ~rd_byte[bit_idx];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sreg_slave_top.sv
module sreg_slave_top
    import sreg_pkg::*;
#(
    parameter int         NUM_REGS    = 128,
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] WR_ADDR     = 8'h24,
    parameter logic [7:0] RD_ADDR     = 8'h25
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_clk_i,
    input  logic                       bus_data_i,
    output logic                       ack_o,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    localparam int PTR_W = $clog2(NUM_REGS);

    bus_ev_t           ev;
    logic              we;
    logic [PTR_W-1:0]  waddr;
    logic [DATA_W-1:0] wdata;
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] rd_byte;
    slv_state_e        state;

    sreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_pin (bus_clk_i),
        .sda_pin (bus_data_i),
        .ev      (ev)
    );

    sreg_ctrl #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .WR_ADDR  (WR_ADDR),
        .RD_ADDR  (RD_ADDR)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_byte (rd_byte),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .ptr     (ptr),
        .ack_o   (ack_o),
        .state   (state)
    );

    sreg_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (ptr),
        .rdata (rd_byte),
        .flat  (regs_o)
    );

endmodule

// File: rtl/sreg_slave_chk.sv
module sreg_slave_chk
    import sreg_pkg::*;
#(
    parameter int NUM_REGS = 128,
    parameter int DATA_W   = 8,
    localparam int PTR_W   = $clog2(NUM_REGS)
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       start_ev,
    input logic                       stop_ev,
    input logic                       scl_fall,
    input logic                       ack_o,
    input slv_state_e                 state,
    input logic                       we,
    input logic [PTR_W-1:0]           waddr,
    input logic [DATA_W-1:0]          wdata,
    input logic [PTR_W-1:0]           ptr,
    input logic [NUM_REGS*DATA_W-1:0] regs_o
);
    p_start_clears_r1: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> (!ack_o && state == ST_ADDR));

    p_stop_frees_r2: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> (!ack_o && state == ST_IDLE));

    p_idle_silent_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !ack_o);

    p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
        we |=> (regs_o[$past(waddr)*DATA_W +: DATA_W] == $past(wdata)));

    p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == '1) |-> (ptr == '0));

    p_ignore_silent_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !ack_o);

    p_ack_on_fall_r13: assert property (@(posedge clk) disable iff (rst)
        !$stable(ack_o) |-> $past(scl_fall || start_ev || stop_ev));

endmodule

bind sreg_slave_top sreg_slave_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .start_ev (ev.start),
    .stop_ev  (ev.stop),
    .scl_fall (ev.fall),
    .ack_o    (ack_o),
    .state    (state),
    .we       (we),
    .waddr    (waddr),
    .wdata    (wdata),
    .ptr      (ptr),
    .regs_o   (regs_o)
);

// File: tb/sreg_slave_tb.sv
module sreg_slave_top_tb_top;
    localparam int NR = 128;
    localparam int DW = 8;
    localparam int H  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic ack_o;
    logic [NR*DW-1:0] regs_o;

    int total = 0;
    int fails = 0;
    int mism  = 0;
    bit cmp_en = 1'b0;
    logic [7:0] mdl [NR];

    sreg_slave_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_clk_i  (scl),
        .bus_data_i (sda),
        .ack_o      (ack_o),
        .regs_o     (regs_o)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (cmp_en) begin
            for (int a = 0; a < NR; a++)
                if (regs_o[a*DW +: DW] !== mdl[a]) mism++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] reg_at(input int a);
        return regs_o[a*DW +: DW];
    endfunction

    task automatic bus_start();
        sda = 1'b1; tick(H);
        scl = 1'b1; tick(H);
        sda = 1'b0; tick(H);
        scl = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda = 1'b0; tick(H);
        scl = 1'b1; tick(H);
        sda = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked,
                             input bit lat = 1'b0, input bit skip = 1'b0);
        for (int i = 7; i >= 0; i--) begin
            sda = b[i]; tick(H);
            scl = 1'b1; tick(H);
            scl = 1'b0;
            if (i == 0 && lat) begin
                tick(2);
                chk(ack_o == 1'b0, "R13 ack not yet at edge 2", ack_o, 0);
                tick(1);
                chk(ack_o == 1'b1, "R13 ack at edge 3", ack_o, 1);
                tick(H - 3);
            end else begin
                tick(H);
            end
        end
        acked = ack_o;
        if (!skip) begin
            sda = 1'b1; tick(H);
            acked = acked & ack_o;
            scl = 1'b1; tick(H);
            acked = acked & ack_o;
            scl = 1'b0; tick(H);
        end
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit mack);
        for (int i = 7; i >= 0; i--) begin
            b[i] = ~ack_o;
            scl = 1'b1; tick(H);
            scl = 1'b0; tick(H);
        end
        sda = mack ? 1'b0 : 1'b1; tick(H);
        chk(ack_o == 1'b0, "R8 output low in host ack slot", ack_o, 0);
        scl = 1'b1; tick(H);
        scl = 1'b0; tick(H);
        sda = 1'b1; tick(H);
    endtask

    initial begin
        bit a;
        logic [7:0] rb;
        for (int i = 0; i < NR; i++) mdl[i] = 8'h00;
        tick(4);
        rst = 1'b0;
        tick(2);

        // R12 reset state
        chk(ack_o == 1'b0, "R12 ack low after reset", ack_o, 0);
        chk(regs_o == '0, "R12 registers zero", regs_o[31:0], 0);
        cmp_en = 1'b1;

        // R4 R5 R6 R3: single write, AA distinguishes bit order
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'h24, a); chk(a, "R4 write address acked", a, 1);
        send_byte(8'h00, a); chk(a, "R5 pointer byte acked", a, 1);
        send_byte(8'hAA, a); chk(a, "R6 data byte acked", a, 1);
        bus_stop();
        mdl[0] = 8'hAA;
        chk(reg_at(0) == 8'hAA, "R3 msb first stored", reg_at(0), 8'hAA);
        cmp_en = 1'b1;

        // R7 R6 R13: burst across the wrap point
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'h24, a);
        send_byte(8'h7E, a);
        send_byte(8'h11, a, 1'b1);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        send_byte(8'h44, a); chk(a, "R6 fourth burst byte acked", a, 1);
        bus_stop();
        mdl[8'h7E] = 8'h11; mdl[8'h7F] = 8'h22; mdl[0] = 8'h33; mdl[1] = 8'h44;
        chk(reg_at(8'h7F) == 8'h22, "R6 burst byte at 7F", reg_at(8'h7F), 8'h22);
        chk(reg_at(0) == 8'h33, "R7 wrap to 00", reg_at(0), 8'h33);
        chk(reg_at(1) == 8'h44, "R7 wrap continues at 01", reg_at(1), 8'h44);
        cmp_en = 1'b1;

        // R11 R8 R9: set pointer, stop, read across wrap, then NAK
        bus_start();
        send_byte(8'h24, a);
        send_byte(8'h7E, a);
        bus_stop();
        bus_start();
        send_byte(8'h25, a); chk(a, "R8 read address acked", a, 1);
        recv_byte(rb, 1'b1); chk(rb == 8'h11, "R11 read starts at set pointer", rb, 8'h11);
        recv_byte(rb, 1'b1); chk(rb == 8'h22, "R8 second read byte", rb, 8'h22);
        recv_byte(rb, 1'b0); chk(rb == 8'h33, "R8 read wraps to 00", rb, 8'h33);
        recv_byte(rb, 1'b1); chk(rb == 8'hFF, "R9 output silent after NAK", rb, 8'hFF);
        bus_stop();

        // R10: unmatched address
        bus_start();
        send_byte(8'h30, a); chk(!a, "R10 foreign address not acked", a, 0);
        send_byte(8'h00, a); chk(!a, "R10 later byte not acked", a, 0);
        send_byte(8'h55, a);
        bus_stop();
        chk(reg_at(0) == 8'h33, "R10 register 00 unchanged", reg_at(0), 8'h33);

        // R2: traffic after stop without a start
        scl = 1'b0; tick(H);
        send_byte(8'h24, a); chk(!a, "R2 no ack without start", a, 0);
        send_byte(8'h02, a);
        send_byte(8'h99, a); chk(!a, "R2 no ack on data", a, 0);
        scl = 1'b1; tick(H);
        bus_stop();
        chk(reg_at(2) == 8'h00, "R2 register 02 unchanged", reg_at(2), 0);

        // R1: repeated start while acknowledge is high
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'h24, a);
        send_byte(8'h05, a, 1'b0, 1'b1);
        chk(ack_o == 1'b1, "R4 ack high before restart", ack_o, 1);
        bus_start();
        chk(ack_o == 1'b0, "R1 start drops ack", ack_o, 0);
        send_byte(8'h24, a); chk(a, "R1 address after restart acked", a, 1);
        send_byte(8'h10, a);
        send_byte(8'h5A, a);
        bus_stop();
        mdl[8'h10] = 8'h5A;
        chk(reg_at(5) == 8'h00, "R1 aborted transfer wrote nothing", reg_at(5), 0);
        chk(reg_at(8'h10) == 8'h5A, "R1 write after restart", reg_at(8'h10), 8'h5A);
        cmp_en = 1'b1;
        tick(4);

        chk(mism == 0, "R6 register mirror every clock", mism, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule